// File: doc/BRIEF.md
# I2C 10-bit Address Slave Transmitter

This block is a bus slave that answers a ten-bit address and then returns data bytes to the bus master. SCL and SDA are sampled through a synchronizer running on a fast system clock. The block pulls either line low through open-drain enables. The register side sees a transmit buffer with a write strobe, a buffer-full flag, an interrupt flag, a clock-release bit and an address-update request with its acknowledge strobe.

A master first sends a write header, which holds the two upper address bits. The low address byte follows. After a repeated start the master sends the header again, this time with the read bit set. The block acknowledges each address byte that matches `own_addr_i`. After each of the two address bytes it holds SCL low until the register side completes the address-update handshake. Once the read header is acknowledged, the block holds SCL low before every byte it sends, until the clock-release bit is set. Data bytes written by the master after a matched low byte are acknowledged and are not stretched.

Top module: `i2c10_slave_tx`

## Requirements
- R1: SDA falling while SCL is high starts reception of a header byte from any state. SDA rising while SCL is high returns the block to idle, releases both lines and forgets an earlier low-byte match.
- R2: A header byte is matched when its bits 7..3 are 11110, its bits 2..1 equal `own_addr_i[9:8]`, and bit 0 (R/W) is 0. On a match the block holds SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R3: After each acknowledged header write byte and each acknowledged low byte, `addr_upd_o` rises at the ninth SCL falling edge and SCL is held low. A pulse on `addr_ack_i` clears the flag and releases SCL.
- R4: A low byte, sent MSB first, is acknowledged only when it equals `own_addr_i[7:0]`. On a mismatch SDA stays released, `addr_upd_o` stays low, and no later byte is acknowledged before a new start.
- R5: A header with R/W=1 is acknowledged only if a low byte has matched since the last stop. On its ninth falling edge `rel_o` is cleared and SCL is held low.
- R6: Setting `rel_o` through `rel_set_i` releases SCL. The buffered byte is then driven MSB first on clocks 1 to 8, and SDA is released for clock 9.
- R7: `tx_wr_i` loads the transmit buffer and sets `buf_full_o`. The ninth falling edge of a transmitted byte clears `buf_full_o`.
- R8: Every acknowledged received byte (address or data) loads `rx_data_o` and sets `buf_full_o` at its ninth falling edge. `rx_rd_i` clears `buf_full_o`.
- R9: `irq_o` is set at the ninth falling edge of every acknowledged or transmitted byte. Only `irq_clr_i` clears it.
- R10: If the master ACKs a transmitted byte, `rel_o` is cleared and SCL is held low again. If the master NACKs it, both lines are released and stay released until a start.
- R11: Bytes written by the master after a matched low byte are acknowledged, appear on `rx_data_o`, and cause no clock stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| own_addr_i | input | 10 | Slave address |
| tx_data_i | input | 8 | Transmit buffer write data |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| rx_data_o | output | 8 | Last acknowledged received byte |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| buf_full_o | output | 1 | Buffer-full flag |
| irq_o | output | 1 | Interrupt flag |
| irq_clr_i | input | 1 | Interrupt clear strobe |
| rel_set_i | input | 1 | Sets the clock-release bit |
| rel_o | output | 1 | Clock-release bit |
| addr_upd_o | output | 1 | Address-update request |
| addr_ack_i | input | 1 | Address-update acknowledge strobe |

## Verification
The bench builds the block with a three-stage synchronizer instead of the default two. This confirms that a deeper input path only delays edge detection and does not reorder the start, stop and data edges. The bus runs at a half period of sixteen system clocks, which leaves the slave's ACK, data and stretch decisions several cycles of margin inside each SCL phase. The slave address is set to 0x2D6, so that both header address bits and the low byte hold mixed ones and zeros, and single-bit mismatches in the header and the low byte can be tested.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] HDR_PAT = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_AHOLD, PH_TXH, PH_TX, PH_RACK
  } ph_e;

  typedef enum logic [1:0] {K_HDR, K_LOW, K_DATA} kind_e;
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] in_i,
  output logic [LINES-1:0] out_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], in_i[l]};
    end
    assign out_o[l] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/i2c10_cond.sv
module i2c10_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c10_flags.sv
module i2c10_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_wr_i,
  input  logic rx_byte_i,
  input  logic tx_done_i,
  input  logic rx_rd_i,
  input  logic irq_set_i,
  input  logic irq_clr_i,
  input  logic upd_set_i,
  input  logic upd_clr_i,
  input  logic rel_set_i,
  input  logic rel_clr_i,
  output logic bf_o,
  output logic irq_o,
  output logic upd_o,
  output logic rel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bf_o  <= 1'b0;
      irq_o <= 1'b0;
      upd_o <= 1'b0;
      rel_o <= 1'b0;
    end else begin
      if (tx_wr_i || rx_byte_i)      bf_o <= 1'b1;
      else if (tx_done_i || rx_rd_i) bf_o <= 1'b0;
      if (irq_set_i)      irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
      if (upd_set_i)      upd_o <= 1'b1;
      else if (upd_clr_i) upd_o <= 1'b0;
      // hardware clear wins over a concurrent software set
      if (rel_clr_i)      rel_o <= 1'b0;
      else if (rel_set_i) rel_o <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c10_slave_tx.sv
module i2c10_slave_tx
  import i2c10_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic              rx_rd_i,
  output logic              buf_full_o,
  output logic              irq_o,
  input  logic              irq_clr_i,
  input  logic              rel_set_i,
  output logic              rel_o,
  output logic              addr_upd_o,
  input  logic              addr_ack_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [1:0] sync_out;

  i2c10_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i, .rst_ni, .in_i({scl_i, sda_i}), .out_o(sync_out)
  );
  assign scl_s = sync_out[1];
  assign sda_s = sync_out[0];

  i2c10_cond u_cond (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  ph_e               phase_q;
  kind_e             kind_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rsh_q, tsh_q, tx_buf_q;
  logic              addr_ok_q, mack_q;
  logic              rx_byte, tx_done, irq_set, upd_set, rel_clr;
  logic              hdr_hit, low_hit, byte_hit;

  assign hdr_hit = (rsh_q[7:3] == HDR_PAT) && (rsh_q[2:1] == own_addr_i[9:8])
                   && (!rsh_q[0] || addr_ok_q);
  assign low_hit = rsh_q == own_addr_i[7:0];
  always_comb begin
    unique case (kind_q)
      K_HDR:   byte_hit = hdr_hit;
      K_LOW:   byte_hit = low_hit;
      default: byte_hit = 1'b1;
    endcase
  end

  wire ack_end  = (phase_q == PH_ACK) && scl_fall && !start_det && !stop_det;
  wire rack_end = (phase_q == PH_RACK) && scl_fall && !start_det && !stop_det;
  wire rd_hdr   = (kind_q == K_HDR) && rsh_q[0];

  assign rx_byte = ack_end;
  assign tx_done = rack_end;
  assign irq_set = ack_end || rack_end;
  assign upd_set = ack_end && (kind_q != K_DATA) && !rd_hdr;
  assign rel_clr = (ack_end && rd_hdr) || (rack_end && mack_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_buf_q <= '0;
    else if (tx_wr_i) tx_buf_q <= tx_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      kind_q    <= K_HDR;
      cnt_q     <= '0;
      rsh_q     <= '0;
      tsh_q     <= '0;
      rx_data_o <= '0;
      addr_ok_q <= 1'b0;
      mack_q    <= 1'b0;
    end else if (stop_det) begin
      phase_q   <= PH_IDLE;
      addr_ok_q <= 1'b0;
    end else if (start_det) begin
      phase_q <= PH_RX;
      kind_q  <= K_HDR;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && cnt_q != CNT_W'(BYTE_W)) begin
            rsh_q <= {rsh_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            phase_q <= byte_hit ? PH_ACK : PH_IDLE;
          end
        end
        PH_ACK: if (scl_fall) begin
          rx_data_o <= rsh_q;
          cnt_q     <= '0;
          unique case (kind_q)
            K_HDR: if (rsh_q[0]) phase_q <= PH_TXH;
                   else begin
                     phase_q   <= PH_AHOLD;
                     kind_q    <= K_LOW;
                     addr_ok_q <= 1'b0;
                   end
            K_LOW: begin
              phase_q   <= PH_AHOLD;
              kind_q    <= K_DATA;
              addr_ok_q <= 1'b1;
            end
            default: phase_q <= PH_RX;
          endcase
        end
        PH_AHOLD: if (addr_ack_i) phase_q <= PH_RX;
        PH_TXH: if (rel_o) begin
          tsh_q   <= tx_buf_q;
          cnt_q   <= '0;
          phase_q <= PH_TX;
        end
        PH_TX: if (scl_fall) begin
          tsh_q <= {tsh_q[BYTE_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(BYTE_W - 1)) phase_q <= PH_RACK;
        end
        PH_RACK: begin
          if (scl_rise) mack_q <= !sda_s;
          if (scl_fall) phase_q <= mack_q ? PH_TXH : PH_IDLE;
        end
        default: ;
      endcase
    end
  end

  i2c10_flags u_flags (
    .clk_i, .rst_ni,
    .tx_wr_i, .rx_byte_i(rx_byte), .tx_done_i(tx_done), .rx_rd_i,
    .irq_set_i(irq_set), .irq_clr_i,
    .upd_set_i(upd_set), .upd_clr_i(addr_ack_i),
    .rel_set_i, .rel_clr_i(rel_clr),
    .bf_o(buf_full_o), .irq_o, .upd_o(addr_upd_o), .rel_o
  );

  assign scl_oe_o = (phase_q == PH_AHOLD) || (phase_q == PH_TXH);
  assign sda_oe_o = (phase_q == PH_ACK)
                 || ((phase_q == PH_TXH) && !tx_buf_q[BYTE_W-1])
                 || ((phase_q == PH_TX) && !tsh_q[BYTE_W-1]);
endmodule

// File: rtl/i2c10_slave_tx_chk.sv
module i2c10_slave_tx_chk
  import i2c10_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input ph_e  phase,
  input logic stop_det,
  input logic scl_oe,
  input logic sda_oe,
  input logic upd,
  input logic rel,
  input logic bf,
  input logic irq,
  input logic irq_clr,
  input logic tx_wr
);
  AST_UPD_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd) |-> scl_oe); // R3
  AST_RD_HOLD_REL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_TXH && $past(phase) != PH_TXH) |-> !rel); // R5
  AST_BF_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr |=> bf); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq && !irq_clr) |=> irq); // R9
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (!scl_oe && !sda_oe)); // R1
endmodule

bind i2c10_slave_tx i2c10_slave_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .phase(phase_q), .stop_det(stop_det),
  .scl_oe(scl_oe_o), .sda_oe(sda_oe_o), .upd(addr_upd_o), .rel(rel_o),
  .bf(buf_full_o), .irq(irq_o), .irq_clr(irq_clr_i), .tx_wr(tx_wr_i)
);

// File: tb/i2c10_slave_tx_tb_top.sv
module i2c10_slave_tx_tb_top;
  localparam int T = 16;
  localparam logic [9:0] ADDR = 10'h2D6;
  localparam logic [7:0] HW = 8'hF4, HR = 8'hF5, HBAD = 8'hF2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, tx_wr = 0, rx_rd = 0, irq_clr = 0, rel_set = 0, addr_ack = 0;
  logic [7:0] tx_data = '0, rx_data;
  logic bf, irq, rel, upd;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  i2c10_slave_tx #(.SYNC_STAGES(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(ADDR),
    .tx_data_i(tx_data), .tx_wr_i(tx_wr), .rx_data_o(rx_data), .rx_rd_i(rx_rd),
    .buf_full_o(bf), .irq_o(irq), .irq_clr_i(irq_clr), .rel_set_i(rel_set),
    .rel_o(rel), .addr_upd_o(upd), .addr_ack_i(addr_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bit_w(input logic b);
    m_sda = b; wc(T); m_scl = 1; wait_high(); wc(T); m_scl = 0; wc(T);
  endtask

  task automatic bit_r(output logic b);
    m_sda = 1; wc(T); m_scl = 1; wait_high(); wc(T / 2);
    b = sda_bus; wc(T / 2); m_scl = 0; wc(T);
  endtask

  task automatic byte_w(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(a);
    ack = !a;
  endtask

  task automatic byte_r(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_r(b); d[i] = b; end
  endtask

  task automatic start_c(); m_sda = 0; wc(T); m_scl = 0; wc(T); endtask
  task automatic rstart_c();
    m_sda = 1; wc(T); m_scl = 1; wait_high(); wc(T); m_sda = 0; wc(T); m_scl = 0; wc(T);
  endtask
  task automatic stop_c();
    m_sda = 0; wc(T); m_scl = 1; wait_high(); wc(T); m_sda = 1; wc(T);
  endtask

  task automatic pulse_rx_rd();   rx_rd = 1;   wc(1); rx_rd = 0;   endtask
  task automatic pulse_irq_clr(); irq_clr = 1; wc(1); irq_clr = 0; endtask
  task automatic pulse_ack();     addr_ack = 1; wc(1); addr_ack = 0; endtask
  task automatic pulse_rel();     rel_set = 1; wc(1); rel_set = 0; endtask
  task automatic write_tx(input logic [7:0] d);
    tx_data = d; tx_wr = 1; wc(1); tx_wr = 0;
  endtask

  task automatic clear_all();
    pulse_rx_rd(); pulse_irq_clr(); wc(2);
  endtask

  // header write + low byte, with handshake checks
  task automatic address_phase(input string tag);
    logic ack;
    start_c();
    byte_w(HW, ack);
    chk({"R2 header ack ", tag}, ack, 1);
    chk({"R3 upd after header ", tag}, upd, 1);
    chk({"R3 scl held ", tag}, scl_oe, 1);
    chk({"R8 bf on header ", tag}, bf, 1);
    chk({"R8 rx_data header ", tag}, rx_data, HW);
    wc(3 * T);
    chk({"R3 still held ", tag}, scl_oe, 1);
    clear_all(); pulse_ack(); wc(2);
    chk({"R3 upd cleared ", tag}, upd, 0);
    chk({"R3 scl released ", tag}, scl_oe, 0);
    byte_w(ADDR[7:0], ack);
    chk({"R4 low ack ", tag}, ack, 1);
    chk({"R3 upd after low ", tag}, upd, 1);
    chk({"R3 scl held low ", tag}, scl_oe, 1);
    clear_all(); pulse_ack(); wc(2);
  endtask

  task automatic t_reset();
    chk("R1 reset scl_oe", scl_oe, 0);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R8 reset bf", bf, 0);
    chk("R9 reset irq", irq, 0);
    chk("R3 reset upd", upd, 0);
    chk("R5 reset rel", rel, 0);
  endtask

  task automatic t_write();
    logic ack;
    address_phase("wr");
    byte_w(8'hA5, ack);
    chk("R11 data ack", ack, 1);
    chk("R11 rx_data", rx_data, 8'hA5);
    chk("R11 no stretch", scl_oe, 0);
    chk("R9 irq on data", irq, 1);
    wc(4 * T);
    chk("R9 irq sticky", irq, 1);
    pulse_irq_clr(); wc(1);
    chk("R9 irq cleared", irq, 0);
    pulse_rx_rd(); wc(1);
    chk("R8 rx_rd clears bf", bf, 0);
    byte_w(8'h3B, ack);
    chk("R11 second data ack", ack, 1);
    chk("R11 second rx_data", rx_data, 8'h3B);
    clear_all();
    stop_c();
    chk("R1 stop release scl", scl_oe, 0);
    chk("R1 stop release sda", sda_oe, 0);
  endtask

  task automatic t_read();
    logic ack; logic [7:0] d;
    address_phase("rd");
    rstart_c();
    byte_w(HR, ack);
    chk("R5 read header ack", ack, 1);
    chk("R5 rel cleared", rel, 0);
    chk("R5 scl held", scl_oe, 1);
    chk("R3 no upd on read hdr", upd, 0);
    clear_all();
    write_tx(8'h3C);
    chk("R7 bf on write", bf, 1);
    wc(3 * T);
    chk("R5 held until rel", scl_oe, 1);
    pulse_rel();
    byte_r(d);
    chk("R6 byte 1 data", d, 8'h3C);
    chk("R6 sda free on clk9", sda_oe, 0);
    bit_w(1'b0);
    chk("R7 bf cleared", bf, 0);
    chk("R9 irq on tx", irq, 1);
    chk("R10 rel cleared after ack", rel, 0);
    chk("R10 restretch after ack", scl_oe, 1);
    pulse_irq_clr();
    write_tx(8'hC1);
    pulse_rel();
    byte_r(d);
    chk("R6 byte 2 data", d, 8'hC1);
    bit_w(1'b1);
    chk("R10 nack release scl", scl_oe, 0);
    chk("R10 nack release sda", sda_oe, 0);
    wc(4 * T);
    chk("R10 stays released", scl_oe, 0);
    clear_all();
    stop_c();
  endtask

  task automatic t_bad_header();
    logic ack;
    start_c();
    byte_w(HBAD, ack);
    chk("R2 bad header nack", ack, 0);
    chk("R3 no upd on bad hdr", upd, 0);
    chk("R9 no irq on bad hdr", irq, 0);
    byte_w(ADDR[7:0], ack);
    chk("R2 ignored after bad hdr", ack, 0);
    chk("R2 scl free", scl_oe, 0);
    stop_c();
  endtask

  task automatic t_bad_low();
    logic ack;
    start_c();
    byte_w(HW, ack);
    chk("R2 header ack bl", ack, 1);
    clear_all(); pulse_ack(); wc(2);
    byte_w(ADDR[7:0] ^ 8'h01, ack);
    chk("R4 low mismatch nack", ack, 0);
    chk("R4 no upd", upd, 0);
    chk("R4 bf untouched", bf, 0);
    byte_w(8'h55, ack);
    chk("R4 later data ignored", ack, 0);
    rstart_c();
    byte_w(HR, ack);
    chk("R5 read hdr nack w/o low", ack, 0);
    stop_c();
  endtask

  task automatic t_read_after_stop();
    logic ack;
    address_phase("st");
    stop_c();
    start_c();
    byte_w(HR, ack);
    chk("R1 stop forgets low match", ack, 0);
    chk("R5 scl free", scl_oe, 0);
    stop_c();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wc(5); rst_n = 1; wc(5);
    t_reset();
    t_write();
    t_read();
    t_bad_header();
    t_bad_low();
    t_read_after_stop();
    wc(10);
    finish_run();
  end
endmodule